// File: doc/BRIEF.md
# Defect Recovery Sequencer

This block sits between a set of hardware defect detectors and the core that must recover from them. Each detector raises one flag when it sees the signal combination of a known design defect. The block latches every flag into a sticky pending register. When any bit is pending, it asks the pipeline for a flush and a redirect to the recovery entry point, then carries out the recovery path that software has chosen for that flag.

Software gives each flag a 2-bit recovery class, a watch-window length and a flag that says whether rollback is supported. A retry class disables one contributing signal, resumes, and watches the same detector for a programmable number of cycles. If the detector stays quiet, the defect counts as averted and the signal is turned back on. If it fires again, the block flushes once more and requests software emulation of the next few instructions. A third firing sends the defect to the exception path. A confined-damage class does the same and also pulses a reset into the corrupted module. The escalation class never retries: it requests a checkpoint rollback when rollback is supported, and raises an exception otherwise. The pipeline, the emulation code and the checkpoint hardware appear only as request/acknowledge pairs.

Top module: `defect_recovery_seq`

## Requirements
- R1: A high `flag_in[i]` sets `defects[i]` at the next clock edge. The bit stays set until the recovery of flag i completes. A new flag wins over a clear in the same cycle.
- R2: When a bit is pending and the block is idle, `flush_req` rises one cycle later and is held until `flush_ack`. `active_id` gives the index of the flag being serviced.
- R3: Class 2'b00 (retry): on `flush_ack`, `sig_disable[id]` is set and a watch window of `cfg_watch_len`+1 cycles starts. If the flag does not fire in that window, the edge that ends the window clears `sig_disable` and `defects[id]`.
- R4: If the serviced flag fires during the first watch window, the block issues a new `flush_req`. After its acknowledge it holds `emul_req` until `emul_ack`, then starts a new watch window. `sig_disable[id]` stays set throughout.
- R5: Class 2'b01 (retry with reset) behaves as R3/R4. In addition, `mod_reset[id]` is high for exactly one cycle after each flush acknowledge.
- R6: Class 2'b10 or 2'b11 (escalate): after the flush acknowledge, no signal is disabled. The block holds `rollback_req` when `cfg_rollback_ok`=1, and `exc_req` otherwise, until the matching acknowledge. The acknowledge completes the recovery.
- R7: When several bits are pending, the lowest index is serviced first. The other bits stay set and are serviced afterwards.
- R8: If the serviced flag fires during the watch window that follows emulation, the block holds `exc_req` until `exc_ack`, then completes.
- R9: At most one of `flush_req`, `emul_req`, `rollback_req` and `exc_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_in | input | NFLAG | Detector outputs, one per defect |
| cfg_class | input | 2*NFLAG | Recovery class per flag, bits [2i+1:2i] for flag i |
| cfg_rollback_ok | input | 1 | Checkpoint rollback is available |
| cfg_watch_len | input | TW | Watch window reload value |
| defects | output | NFLAG | Sticky pending defects |
| active_id | output | $clog2(NFLAG) | Index of the flag under recovery |
| flush_req | output | 1 | Pipeline flush and redirect request |
| flush_ack | input | 1 | Flush completed |
| sig_disable | output | NFLAG | Disable of the signal that contributes to flag i |
| mod_reset | output | NFLAG | One-cycle reset of the module tied to flag i |
| emul_req | output | 1 | Request software emulation of the next instructions |
| emul_ack | input | 1 | Emulation finished |
| rollback_req | output | 1 | Checkpoint rollback request |
| rollback_ack | input | 1 | Rollback finished |
| exc_req | output | 1 | Exception / specialised handler request |
| exc_ack | input | 1 | Exception taken |

## Verification
A single quiet retry measures the exact window edge, so an off-by-one in the timer shows up as a disable that is dropped one cycle early or one cycle late. A single recurrence and a double recurrence separate the emulation path from the exception path. The confined-damage class checks that the reset is a one-cycle pulse, and the escalation class is run with rollback both supported and unsupported. Two flags raised in the same cycle show that the lower index is serviced first and that the higher one stays pending until its own turn.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLUSH = 3'd1,
        ST_EMUL  = 3'd2,
        ST_WATCH = 3'd3,
        ST_ROLL  = 3'd4,
        ST_EXC   = 3'd5
    } rec_state_t;

    typedef logic [1:0] rec_class_t;
    localparam rec_class_t CLS_RETRY    = 2'b00;
    localparam rec_class_t CLS_RETRY_RS = 2'b01;

    // escalation classes have the upper bit set
    function automatic logic cls_escalates(input rec_class_t c);
        return c[1];
    endfunction

    function automatic logic cls_resets(input rec_class_t c);
        return (c == CLS_RETRY_RS);
    endfunction
endpackage

// File: rtl/dr_flag_bank.sv
module dr_flag_bank #(
    parameter int NFLAG = 8,
    localparam int IDW = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] flag_in,
    input  logic             clr_en,
    input  logic [IDW-1:0]   clr_id,
    output logic [NFLAG-1:0] pending,
    output logic             pend_any,
    output logic [IDW-1:0]   pend_id
);
    genvar g;
    generate
        for (g = 0; g < NFLAG; g++) begin : g_bit
            logic bit_q;
            logic clr_hit;
            assign clr_hit = clr_en && (clr_id == IDW'(g));
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (flag_in[g])
                    bit_q <= 1'b1;
                else if (clr_hit)
                    bit_q <= 1'b0;
            end
            assign pending[g] = bit_q;
        end
    endgenerate

    assign pend_any = |pending;

    always_comb begin
        pend_id = '0;
        for (int i = NFLAG - 1; i >= 0; i--) begin
            if (pending[i])
                pend_id = IDW'(i);
        end
    end
endmodule

// File: rtl/dr_watch_timer.sv
module dr_watch_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    input  logic          run,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - TW'(1);
    end

    assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/dr_seq_fsm.sv
module dr_seq_fsm
    import dr_pkg::*;
#(
    parameter int NFLAG = 8,
    localparam int IDW = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NFLAG-1:0]   flag_in,
    input  logic [2*NFLAG-1:0] cfg_class,
    input  logic               cfg_rollback_ok,
    input  logic               pend_any,
    input  logic [IDW-1:0]     pend_id,
    input  logic               tmr_expired,
    input  logic               flush_ack,
    input  logic               emul_ack,
    input  logic               rollback_ack,
    input  logic               exc_ack,
    output logic               clr_en,
    output logic               tmr_load,
    output logic               tmr_run,
    output logic [IDW-1:0]     id,
    output logic               flush_req,
    output logic               emul_req,
    output logic               rollback_req,
    output logic               exc_req,
    output logic [NFLAG-1:0]   sig_disable,
    output logic [NFLAG-1:0]   mod_reset
);
    rec_state_t state_q, state_n;
    logic       emu_q, emu_n;
    logic       dis_q, dis_n;
    logic       pulse_q, pulse_n;
    logic       take;
    rec_class_t cls;
    logic [NFLAG-1:0] id_onehot;

    assign cls = cfg_class[{id, 1'b0} +: 2];

    always_comb begin
        state_n  = state_q;
        emu_n    = emu_q;
        dis_n    = dis_q;
        pulse_n  = 1'b0;
        tmr_load = 1'b0;
        clr_en   = 1'b0;
        take     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_any) begin
                    take    = 1'b1;
                    emu_n   = 1'b0;
                    state_n = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (flush_ack) begin
                    if (cls_escalates(cls)) begin
                        state_n = cfg_rollback_ok ? ST_ROLL : ST_EXC;
                    end else begin
                        dis_n   = 1'b1;
                        pulse_n = cls_resets(cls);
                        if (emu_q) begin
                            state_n = ST_EMUL;
                        end else begin
                            state_n  = ST_WATCH;
                            tmr_load = 1'b1;
                        end
                    end
                end
            end
            ST_EMUL: begin
                if (emul_ack) begin
                    state_n  = ST_WATCH;
                    tmr_load = 1'b1;
                end
            end
            ST_WATCH: begin
                if (flag_in[id]) begin
                    if (emu_q) begin
                        state_n = ST_EXC;
                    end else begin
                        emu_n   = 1'b1;
                        state_n = ST_FLUSH;
                    end
                end else if (tmr_expired) begin
                    clr_en  = 1'b1;
                    dis_n   = 1'b0;
                    state_n = ST_IDLE;
                end
            end
            ST_ROLL: begin
                if (rollback_ack) begin
                    clr_en  = 1'b1;
                    dis_n   = 1'b0;
                    state_n = ST_IDLE;
                end
            end
            ST_EXC: begin
                if (exc_ack) begin
                    clr_en  = 1'b1;
                    dis_n   = 1'b0;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            emu_q   <= 1'b0;
            dis_q   <= 1'b0;
            pulse_q <= 1'b0;
            id      <= '0;
        end else begin
            state_q <= state_n;
            emu_q   <= emu_n;
            dis_q   <= dis_n;
            pulse_q <= pulse_n;
            if (take)
                id <= pend_id;
        end
    end

    always_comb begin
        id_onehot     = '0;
        id_onehot[id] = 1'b1;
    end

    assign tmr_run      = (state_q == ST_WATCH);
    assign flush_req    = (state_q == ST_FLUSH);
    assign emul_req     = (state_q == ST_EMUL);
    assign rollback_req = (state_q == ST_ROLL);
    assign exc_req      = (state_q == ST_EXC);
    assign sig_disable  = dis_q ? id_onehot : '0;
    assign mod_reset    = pulse_q ? id_onehot : '0;
endmodule

// File: rtl/defect_recovery_seq.sv
module defect_recovery_seq #(
    parameter int NFLAG = 8,
    parameter int TW    = 16,
    localparam int IDW  = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NFLAG-1:0]   flag_in,
    input  logic [2*NFLAG-1:0] cfg_class,
    input  logic               cfg_rollback_ok,
    input  logic [TW-1:0]      cfg_watch_len,
    output logic [NFLAG-1:0]   defects,
    output logic [IDW-1:0]     active_id,
    output logic               flush_req,
    input  logic               flush_ack,
    output logic [NFLAG-1:0]   sig_disable,
    output logic [NFLAG-1:0]   mod_reset,
    output logic               emul_req,
    input  logic               emul_ack,
    output logic               rollback_req,
    input  logic               rollback_ack,
    output logic               exc_req,
    input  logic               exc_ack
);
    logic           clr_en;
    logic           pend_any;
    logic [IDW-1:0] pend_id;
    logic           tmr_load;
    logic           tmr_run;
    logic           tmr_expired;

    dr_flag_bank #(.NFLAG(NFLAG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .flag_in  (flag_in),
        .clr_en   (clr_en),
        .clr_id   (active_id),
        .pending  (defects),
        .pend_any (pend_any),
        .pend_id  (pend_id)
    );

    dr_watch_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (cfg_watch_len),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    dr_seq_fsm #(.NFLAG(NFLAG)) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .flag_in         (flag_in),
        .cfg_class       (cfg_class),
        .cfg_rollback_ok (cfg_rollback_ok),
        .pend_any        (pend_any),
        .pend_id         (pend_id),
        .tmr_expired     (tmr_expired),
        .flush_ack       (flush_ack),
        .emul_ack        (emul_ack),
        .rollback_ack    (rollback_ack),
        .exc_ack         (exc_ack),
        .clr_en          (clr_en),
        .tmr_load        (tmr_load),
        .tmr_run         (tmr_run),
        .id              (active_id),
        .flush_req       (flush_req),
        .emul_req        (emul_req),
        .rollback_req    (rollback_req),
        .exc_req         (exc_req),
        .sig_disable     (sig_disable),
        .mod_reset       (mod_reset)
    );
endmodule

// File: rtl/defect_recovery_seq_chk.sv
module defect_recovery_seq_chk #(
    parameter int NFLAG = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NFLAG-1:0] flag_in,
    input logic [NFLAG-1:0] defects,
    input logic             flush_req,
    input logic             flush_ack,
    input logic [NFLAG-1:0] sig_disable,
    input logic [NFLAG-1:0] mod_reset,
    input logic             emul_req,
    input logic             emul_ack,
    input logic             rollback_req,
    input logic             rollback_ack,
    input logic             exc_req,
    input logic             exc_ack
);
    p_flag_sticks_r1: assert property (@(posedge clk) disable iff (rst)
        (|flag_in) |=> ((defects & $past(flag_in)) == $past(flag_in)));

    p_flush_held_r2: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_ack) |=> flush_req);

    p_flush_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (|defects));

    p_disable_single_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sig_disable));

    p_emul_held_r4: assert property (@(posedge clk) disable iff (rst)
        (emul_req && !emul_ack) |=> emul_req);

    p_reset_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (|mod_reset) |=> (mod_reset == '0));

    p_reset_single_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mod_reset));

    p_rollback_held_r6: assert property (@(posedge clk) disable iff (rst)
        (rollback_req && !rollback_ack) |=> rollback_req);

    p_exc_held_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !exc_ack) |=> exc_req);

    p_one_request_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_req, emul_req, rollback_req, exc_req}));
endmodule

bind defect_recovery_seq defect_recovery_seq_chk #(.NFLAG(NFLAG)) u_chk (.*);

// File: tb/defect_recovery_seq_bench.sv
module defect_recovery_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NF  = 8;
    localparam int TWB = 16;
    localparam int WLEN = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NF-1:0]   flag_in = '0;
    logic [2*NF-1:0] cfg_class = '0;
    logic            cfg_rollback_ok = 1'b0;
    logic [TWB-1:0]  cfg_watch_len = TWB'(WLEN);
    logic [NF-1:0]   defects;
    logic [2:0]      active_id;
    logic            flush_req;
    logic            flush_ack = 1'b0;
    logic [NF-1:0]   sig_disable;
    logic [NF-1:0]   mod_reset;
    logic            emul_req;
    logic            emul_ack = 1'b0;
    logic            rollback_req;
    logic            rollback_ack = 1'b0;
    logic            exc_req;
    logic            exc_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    defect_recovery_seq #(.NFLAG(NF), .TW(TWB)) u_defect_recovery_seq (
        .clk(clk), .rst(rst), .flag_in(flag_in), .cfg_class(cfg_class),
        .cfg_rollback_ok(cfg_rollback_ok), .cfg_watch_len(cfg_watch_len),
        .defects(defects), .active_id(active_id),
        .flush_req(flush_req), .flush_ack(flush_ack),
        .sig_disable(sig_disable), .mod_reset(mod_reset),
        .emul_req(emul_req), .emul_ack(emul_ack),
        .rollback_req(rollback_req), .rollback_ack(rollback_ack),
        .exc_req(exc_req), .exc_ack(exc_ack));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<50000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_class(input int f, input logic [1:0] c);
        cfg_class[2*f +: 2] = c;
    endtask

    task automatic pulse_flag(input int f);
        flag_in[f] = 1'b1;
        @(negedge clk);
        flag_in[f] = 1'b0;
    endtask

    task automatic ack_flush(input string tag);
        for (int i = 0; i < 20 && !flush_req; i++) @(negedge clk);
        chk(flush_req === 1'b1, tag, int'(flush_req), 1);
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
    endtask

    task automatic t_reset;
        chk(defects == '0, "R1 reset defects", int'(defects), 0);
        chk({flush_req, emul_req, rollback_req, exc_req} == 4'b0, "R9 reset requests",
            int'({flush_req, emul_req, rollback_req, exc_req}), 0);
        chk(sig_disable == '0 && mod_reset == '0, "R3 reset disable", int'(sig_disable), 0);
    endtask

    // R1 R2 R3: quiet retry, exact window edge
    task automatic t_quiet_retry;
        set_class(3, 2'b00);
        @(negedge clk);
        pulse_flag(3);
        chk(defects[3] === 1'b1, "R1 flag latched", int'(defects), 8);
        chk(flush_req === 1'b0, "R2 flush one cycle later", int'(flush_req), 0);
        @(negedge clk);
        chk(flush_req === 1'b1, "R2 flush raised", int'(flush_req), 1);
        chk(active_id == 3'd3, "R2 active id", int'(active_id), 3);
        step(3);
        chk(flush_req === 1'b1, "R2 flush held without ack", int'(flush_req), 1);
        ack_flush("R2 flush before ack");
        chk(sig_disable == 8'h08, "R3 signal disabled", int'(sig_disable), 8);
        chk(mod_reset == '0, "R3 no module reset", int'(mod_reset), 0);
        step(WLEN);
        chk(sig_disable == 8'h08, "R3 still disabled at last window cycle", int'(sig_disable), 8);
        chk(defects[3] === 1'b1, "R1 bit held during window", int'(defects), 8);
        step(1);
        chk(sig_disable == '0, "R3 disable released", int'(sig_disable), 0);
        chk(defects == '0, "R3 defect cleared", int'(defects), 0);
    endtask

    // R4: one recurrence -> emulation
    task automatic t_emulation;
        set_class(1, 2'b00);
        pulse_flag(1);
        ack_flush("R4 first flush");
        step(2);
        pulse_flag(1);
        chk(flush_req === 1'b1, "R4 reflush on recurrence", int'(flush_req), 1);
        ack_flush("R4 second flush");
        chk(emul_req === 1'b1, "R4 emulation requested", int'(emul_req), 1);
        step(3);
        chk(emul_req === 1'b1, "R4 emulation held", int'(emul_req), 1);
        chk(sig_disable == 8'h02, "R4 disable kept", int'(sig_disable), 2);
        emul_ack = 1'b1;
        @(negedge clk);
        emul_ack = 1'b0;
        chk(emul_req === 1'b0, "R4 emulation dropped", int'(emul_req), 0);
        step(WLEN + 1);
        chk(sig_disable == '0 && defects == '0, "R4 averted after emulation",
            int'(defects), 0);
    endtask

    // R5: retry with module reset pulse
    task automatic t_module_reset;
        set_class(6, 2'b01);
        pulse_flag(6);
        ack_flush("R5 flush");
        chk(mod_reset == 8'h40, "R5 reset pulse", int'(mod_reset), 64);
        chk(sig_disable == 8'h40, "R5 signal disabled", int'(sig_disable), 64);
        step(1);
        chk(mod_reset == '0, "R5 pulse one cycle", int'(mod_reset), 0);
        step(WLEN + 1);
        chk(defects == '0, "R5 completes", int'(defects), 0);
    endtask

    // R6: escalation, both rollback settings
    task automatic t_escalate;
        set_class(4, 2'b10);
        cfg_rollback_ok = 1'b1;
        pulse_flag(4);
        ack_flush("R6 flush rollback");
        chk(rollback_req === 1'b1 && exc_req === 1'b0, "R6 rollback chosen",
            int'(rollback_req), 1);
        chk(sig_disable == '0, "R6 nothing disabled", int'(sig_disable), 0);
        step(2);
        chk(rollback_req === 1'b1, "R6 rollback held", int'(rollback_req), 1);
        rollback_ack = 1'b1;
        @(negedge clk);
        rollback_ack = 1'b0;
        chk(defects == '0 && rollback_req === 1'b0, "R6 rollback completes", int'(defects), 0);
        cfg_rollback_ok = 1'b0;
        set_class(5, 2'b11);
        pulse_flag(5);
        ack_flush("R6 flush exception");
        chk(exc_req === 1'b1 && rollback_req === 1'b0, "R6 exception chosen",
            int'(exc_req), 1);
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
        chk(defects == '0, "R6 exception completes", int'(defects), 0);
    endtask

    // R8: recurrence during emulation window -> exception
    task automatic t_double_recur;
        set_class(0, 2'b00);
        pulse_flag(0);
        ack_flush("R8 first flush");
        pulse_flag(0);
        ack_flush("R8 second flush");
        emul_ack = 1'b1;
        @(negedge clk);
        emul_ack = 1'b0;
        pulse_flag(0);
        chk(exc_req === 1'b1, "R8 exception on second recurrence", int'(exc_req), 1);
        chk(sig_disable == 8'h01, "R8 disable kept until ack", int'(sig_disable), 1);
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
        chk(defects == '0 && sig_disable == '0, "R8 done", int'(defects), 0);
    endtask

    // R7: lowest index first, others pending
    task automatic t_priority;
        set_class(2, 2'b10);
        set_class(7, 2'b10);
        cfg_rollback_ok = 1'b1;
        flag_in = 8'h84;
        @(negedge clk);
        flag_in = '0;
        @(negedge clk);
        chk(active_id == 3'd2, "R7 lowest serviced first", int'(active_id), 2);
        ack_flush("R7 flush first");
        rollback_ack = 1'b1;
        @(negedge clk);
        rollback_ack = 1'b0;
        chk(defects == 8'h80, "R7 higher bit still pending", int'(defects), 128);
        @(negedge clk);
        chk(flush_req === 1'b1 && active_id == 3'd7, "R7 second serviced",
            int'(active_id), 7);
        ack_flush("R7 flush second");
        rollback_ack = 1'b1;
        @(negedge clk);
        rollback_ack = 1'b0;
        chk(defects == '0, "R7 all done", int'(defects), 0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quiet_retry();
        step(2);
        t_emulation();
        step(2);
        t_module_reset();
        step(2);
        t_escalate();
        step(2);
        t_double_recur();
        step(2);
        t_priority();
        step(2);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule